// File: doc/BRIEF.md
# One-Hot Ring State Machine with Codeword Checker

This block is a state machine whose legal states are the one-hot patterns of an N-bit state register. A dedicated ring strobe moves the machine through every legal state in a single fixed loop. The loop starts at the home state, where only bit 0 is set, and each strobe passes the set bit one place toward the MSB. A strobe taken from the MSB state wraps back to home. Each ring step also registers a two-bit code. The code marks a wrap into home apart from a step into any other legal state, so one walk around the loop gives a known code sequence. A combinational checker, linear in N, raises a flag exactly when the register holds a legal codeword.

A clock without the strobe is a normal-mode step and follows a small fixed opcode table. A normal-mode step taken from an illegal pattern always returns the machine to home. A state-load port writes an arbitrary pattern into the register, legal or not, in the way a scan load would. This lets the checker and the recovery paths be exercised.

Top module: `ccoh_ring_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) loads the home state (only bit 0 set) and output code 00. Reset has priority over every other input.
- R2: state_vld is 1 exactly when state_o has exactly one bit set. It follows state_o in the same cycle with no clock delay.
- R3: A ring step (cyc_sym high, ld_en low) taken from a legal state whose set bit is below the MSB moves that bit up one position and registers output code 10.
- R4: A ring step taken from the legal state with only the MSB set returns the machine to home and registers output code 01.
- R5: Starting from home, N consecutive ring steps visit every legal state exactly once, return to home, and produce the code sequence 10 repeated N-1 times followed by 01.
- R6: A normal-mode step (cyc_sym low, ld_en low) taken from a legal state follows norm_op and registers code 00. The opcodes are: 00 holds the state; 01 moves the set bit one position toward bit 0, with bit 0 wrapping to the MSB; 10 goes to home; 11 goes to the state with only bit N/2 set.
- R7: A normal-mode step taken from an illegal pattern loads home and code 00, whatever the value of norm_op.
- R8: In a ring step, each state bit takes the value of the bit one place below it, and bit 0 takes the old MSB. This applies to illegal patterns as well. The code is 01 if the old MSB was set and 10 otherwise.
- R9: ld_en high loads ld_state verbatim and code 00. It overrides cyc_sym and norm_op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the home state |
| ld_en | input | 1 | Load ld_state into the state register |
| ld_state | input | N | Pattern to load, legal or not |
| cyc_sym | input | 1 | Ring step strobe |
| norm_op | input | 2 | Normal-mode opcode |
| out_code | output | 2 | Registered code of the last step: 00 normal/load/reset, 10 ring step, 01 ring wrap |
| state_vld | output | 1 | 1 when state_o is a legal one-hot codeword |
| state_o | output | N | Current state register |

## Verification
State and code are both registered, so every step's result appears at the rising edge that samples its inputs. The checker flag depends only on the register, so it settles in that same cycle. The bench changes inputs on the falling edge and waits one rising edge. It compares state_o, out_code and state_vld on the following falling edge, away from any edge that could race. Every one of the 2^N patterns is loaded and is then followed by a ring step and by a normal-mode step. Each of these is a separate one-cycle transaction, checked against values the bench works out from population count, rotation and the opcode table.

// File: rtl/ccoh_pkg.sv
package ccoh_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_BACK = 2'b01,
        OP_HOME = 2'b10,
        OP_MID  = 2'b11
    } norm_op_e;

    typedef enum logic [1:0] {
        CODE_IDLE = 2'b00,
        CODE_WRAP = 2'b01,
        CODE_STEP = 2'b10,
        CODE_RSVD = 2'b11
    } out_code_e;

endpackage

// File: rtl/ccoh_code_check.sv
// Linear-size codeword checker: one pass over the bits tracks whether
// at least one and at least two ones have been seen.
module ccoh_code_check #(
    parameter int N = 8
) (
    input  logic [N-1:0] state_i,
    output logic         legal_o
);
    logic seen_one;
    logic seen_two;

    always_comb begin
        seen_one = 1'b0;
        seen_two = 1'b0;
        for (int i = 0; i < N; i++) begin
            seen_two = seen_two | (seen_one & state_i[i]);
            seen_one = seen_one | state_i[i];
        end
        legal_o = seen_one & ~seen_two;
    end
endmodule

// File: rtl/ccoh_ring_step.sv
import ccoh_pkg::*;

// Ring-strobe next state: every bit has its own single-wire source,
// and the code depends only on the old MSB.
module ccoh_ring_step #(
    parameter int N = 8
) (
    input  logic [N-1:0] state_i,
    output logic [N-1:0] next_o,
    output out_code_e    code_o
);
    genvar b;
    generate
        for (b = 0; b < N; b++) begin : g_bit
            if (b == 0) begin : g_wrap
                assign next_o[b] = state_i[N-1];
            end else begin : g_shift
                assign next_o[b] = state_i[b-1];
            end
        end
    endgenerate

    assign code_o = state_i[N-1] ? CODE_WRAP : CODE_STEP;
endmodule

// File: rtl/ccoh_norm_step.sv
import ccoh_pkg::*;

// Normal-mode next state: opcode table for legal states,
// unconditional return home for illegal ones.
module ccoh_norm_step #(
    parameter int N = 8
) (
    input  logic [N-1:0] state_i,
    input  logic         legal_i,
    input  norm_op_e     op_i,
    output logic [N-1:0] next_o
);
    localparam int            MID_IDX = N / 2;
    localparam logic [N-1:0]  HOME    = N'(1);
    localparam logic [N-1:0]  MID     = HOME << MID_IDX;

    always_comb begin
        next_o = HOME;
        if (legal_i) begin
            unique case (op_i)
                OP_HOLD: next_o = state_i;
                OP_BACK: next_o = {state_i[0], state_i[N-1:1]};
                OP_HOME: next_o = HOME;
                OP_MID:  next_o = MID;
            endcase
        end
    end
endmodule

// File: rtl/ccoh_ring_fsm.sv
import ccoh_pkg::*;

module ccoh_ring_fsm #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [N-1:0] ld_state,
    input  logic         cyc_sym,
    input  logic [1:0]   norm_op,
    output logic [1:0]   out_code,
    output logic         state_vld,
    output logic [N-1:0] state_o
);
    localparam logic [N-1:0] HOME = N'(1);

    typedef struct packed {
        logic [N-1:0] state;
        out_code_e    code;
    } regs_t;

    regs_t        r_d, r_q;
    logic         legal;
    logic [N-1:0] ring_next;
    out_code_e    ring_code;
    logic [N-1:0] norm_next;

    ccoh_code_check #(.N(N)) u_check (
        .state_i (r_q.state),
        .legal_o (legal)
    );

    ccoh_ring_step #(.N(N)) u_ring (
        .state_i (r_q.state),
        .next_o  (ring_next),
        .code_o  (ring_code)
    );

    ccoh_norm_step #(.N(N)) u_norm (
        .state_i (r_q.state),
        .legal_i (legal),
        .op_i    (norm_op_e'(norm_op)),
        .next_o  (norm_next)
    );

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.state = HOME;
            r_d.code  = CODE_IDLE;
        end else if (ld_en) begin
            r_d.state = ld_state;
            r_d.code  = CODE_IDLE;
        end else if (cyc_sym) begin
            r_d.state = ring_next;
            r_d.code  = ring_code;
        end else begin
            r_d.state = norm_next;
            r_d.code  = CODE_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_o   = r_q.state;
    assign out_code  = r_q.code;
    assign state_vld = legal;

    // Checker flag against an independent population count
    assert_flag_matches_R2: assert property (@(posedge clk) disable iff (rst)
        state_vld == ($countones(state_o) == 1));

    // Step up from a legal non-MSB state
    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        (state_vld && !state_o[N-1] && cyc_sym && !ld_en)
        |=> (out_code == 2'b10) && state_vld && !state_o[0]);

    // Wrap from the MSB state into home
    assert_wrap_home_R4: assert property (@(posedge clk) disable iff (rst)
        (state_vld && state_o[N-1] && cyc_sym && !ld_en)
        |=> (out_code == 2'b01) && (state_o == HOME));

    // Normal hold keeps the state
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_vld && !cyc_sym && !ld_en && norm_op == 2'b00)
        |=> $stable(state_o) && (out_code == 2'b00));

    // Illegal pattern recovers on a normal step
    assert_force_home_R7: assert property (@(posedge clk) disable iff (rst)
        (!state_vld && !cyc_sym && !ld_en)
        |=> (state_o == HOME) && state_vld);

    // Bitwise ring move, legal or not
    assert_bitwise_ring_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc_sym && !ld_en)
        |=> state_o == {$past(state_o[N-2:0]), $past(state_o[N-1])});

    // Load overrides everything but reset
    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (state_o == $past(ld_state)) && (out_code == 2'b00));
endmodule

// File: tb/ccoh_ring_fsm_test.sv
module ccoh_ring_fsm_test;
    localparam int N = 8;
    localparam logic [N-1:0] HOME = N'(1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_en = 1'b0;
    logic [N-1:0] ld_state = '0;
    logic         cyc_sym = 1'b0;
    logic [1:0]   norm_op = 2'b00;
    logic [1:0]   out_code;
    logic         state_vld;
    logic [N-1:0] state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ccoh_ring_fsm #(.N(N)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_state(ld_state),
        .cyc_sym(cyc_sym), .norm_op(norm_op),
        .out_code(out_code), .state_vld(state_vld), .state_o(state_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic l, input logic [N-1:0] lv,
                        input logic c, input logic [1:0] op);
        ld_en = l; ld_state = lv; cyc_sym = c; norm_op = op;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0; cyc_sym = 1'b0; norm_op = 2'b00;
    endtask

    function automatic int popc(input logic [N-1:0] p);
        int n = 0;
        for (int i = 0; i < N; i++) n += int'(p[i]);
        return n;
    endfunction

    function automatic logic [N-1:0] norm_exp(input logic [N-1:0] p, input logic [1:0] op);
        if (popc(p) != 1) return HOME;
        case (op)
            2'b00:   return p;
            2'b01:   return {p[0], p[N-1:1]};
            2'b10:   return HOME;
            default: return HOME << (N / 2);
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset state", 32'(state_o), 32'(HOME));
        check("R1", "reset code", 32'(out_code), 32'h0);
        check("R1", "reset valid", 32'(state_vld), 32'h1);
        rst = 1'b0;

        // R5: two full walks around the ring from home
        for (int lap = 0; lap < 2; lap++) begin
            for (int i = 0; i < N; i++) begin
                step(1'b0, '0, 1'b1, 2'b00);
                if (i < N - 1) begin
                    check("R5", "walk state", 32'(state_o), 32'(HOME << (i + 1)));
                    check("R5", "walk code", 32'(out_code), 32'h2);
                end else begin
                    check("R5", "walk state", 32'(state_o), 32'(HOME));
                    check("R5", "walk code", 32'(out_code), 32'h1);
                end
            end
        end

        // R3 / R4 per legal state, R6 opcode table per legal state
        for (int k = 0; k < N; k++) begin
            step(1'b1, HOME << k, 1'b0, 2'b00);
            step(1'b0, '0, 1'b1, 2'b00);
            if (k == N - 1) begin
                check("R4", "wrap state", 32'(state_o), 32'(HOME));
                check("R4", "wrap code", 32'(out_code), 32'h1);
            end else begin
                check("R3", "step state", 32'(state_o), 32'(HOME << (k + 1)));
                check("R3", "step code", 32'(out_code), 32'h2);
            end
            for (int op = 0; op < 4; op++) begin
                step(1'b1, HOME << k, 1'b0, 2'b00);
                step(1'b0, '0, 1'b0, 2'(op));
                check("R6", "op state", 32'(state_o), 32'(norm_exp(HOME << k, 2'(op))));
                check("R6", "op code", 32'(out_code), 32'h0);
            end
        end

        // Exhaustive pattern sweep: R9 load, R2 flag, R8 ring move, R7 recovery
        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] pat;
            pat = N'(p);
            step(1'b1, pat, 1'b0, 2'b00);
            check("R9", "load state", 32'(state_o), 32'(pat));
            check("R2", "flag", 32'(state_vld), 32'(popc(pat) == 1));
            step(1'b0, '0, 1'b1, 2'b00);
            check("R8", "ring state", 32'(state_o), 32'({pat[N-2:0], pat[N-1]}));
            check("R8", "ring code", 32'(out_code), pat[N-1] ? 32'h1 : 32'h2);
            step(1'b1, pat, 1'b0, 2'b00);
            step(1'b0, '0, 1'b0, pat[1:0]);
            if (popc(pat) != 1) begin
                check("R7", "recover state", 32'(state_o), 32'(HOME));
                check("R7", "recover valid", 32'(state_vld), 32'h1);
            end else begin
                check("R6", "op state", 32'(state_o), 32'(norm_exp(pat, pat[1:0])));
            end
            check("R6", "normal code", 32'(out_code), 32'h0);
        end

        // R9 precedence over strobe and opcode
        step(1'b1, 8'h5A, 1'b1, 2'b11);
        check("R9", "load wins state", 32'(state_o), 32'h5A);
        check("R9", "load wins code", 32'(out_code), 32'h0);

        // R1 reset precedence over load and strobe
        rst = 1'b1;
        step(1'b1, 8'h80, 1'b1, 2'b11);
        rst = 1'b0;
        check("R1", "reset wins state", 32'(state_o), 32'(HOME));
        check("R1", "reset wins code", 32'(out_code), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule